// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block turns a 32-bit instruction word of a small single-cycle processor into the control lines its datapath needs. These lines are the destination-register select, the ALU second-operand select, the write-back source select, the register-file write enable, the memory read and write enables, the branch and jump flags, and a 3-bit ALU operation code. The register file, ALU, memories and program-counter logic sit outside the block and consume these lines.

Decoding happens in two stages. A main decoder looks only at the 6-bit opcode in bits 31..26. Besides the datapath enables, it emits a 2-bit ALU class: 00 means add, 01 means subtract and 10 means "decode the function field". A second stage combines that class with the function field in bits 5..0. Only the low four function bits matter, because bits 5 and 4 are always 10 on legal register-type instructions.

The outputs are registered once on the rising clock edge. A synchronous active-high reset clears them.

Top module: `insn_ctl_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output is 0 on the next cycle, whatever the instruction.
- R2: The outputs change only on a rising clock edge. They show the decode of the instruction present at the previous edge, so a new instruction has no effect before that edge.
- R3: Opcode 0 (register-type) gives `dst_sel_rd`=1 and `reg_wr_en`=1. All other enables, selects and flags are 0, and `alu_ctl` comes from the function field.
- R4: Opcode 35 (load) gives `alu_src_imm`, `wb_sel_mem`, `reg_wr_en` and `mem_rd_en` all 1. `dst_sel_rd`, `mem_wr_en`, `branch_flag` and `jump_flag` are 0, and `alu_ctl`=010 (add).
- R5: Opcode 43 (store) gives `alu_src_imm`=1 and `mem_wr_en`=1. Every other enable, select and flag is 0, `alu_ctl`=010, and `reg_wr_en` and `mem_wr_en` are never 1 together.
- R6: Opcode 4 (branch-if-equal) gives `branch_flag`=1 and `alu_ctl`=110 (subtract). Every other enable, select and flag is 0, whatever bits 5..0 hold.
- R7: `jump_flag` is 1 exactly when the opcode is 2. For opcode 2, every other enable, select and flag is 0, and `alu_ctl`=010.
- R8: Any other opcode drives every enable, select and flag to 0 and gives `alu_ctl`=010.
- R9: For register-type instructions, function bits 3..0 map to `alu_ctl` as follows: 0000 gives 010 (add), 0010 gives 110 (subtract), 0100 gives 000 (AND), 0101 gives 001 (OR) and 1010 gives 111 (set-on-less-than). Function bits 5..4 have no effect.
- R10: A register-type instruction whose function bits 3..0 match none of the codes in R9 gives `alu_ctl`=010.
- R11: `alu_ctl` never takes the values 011, 100 or 101.
- R12: Instruction bits 25..6 have no effect on any output. For opcodes other than 0, bits 5..0 have no effect either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| insn | input | INSN_W (32) | Instruction word to decode |
| dst_sel_rd | output | 1 | 1 selects bits 15..11 as write register, 0 selects bits 20..16 |
| alu_src_imm | output | 1 | 1 selects the sign-extended immediate as ALU operand B |
| wb_sel_mem | output | 1 | 1 writes memory data back, 0 writes the ALU result |
| reg_wr_en | output | 1 | Register-file write enable |
| mem_rd_en | output | 1 | Data-memory read enable |
| mem_wr_en | output | 1 | Data-memory write enable |
| branch_flag | output | 1 | Conditional branch instruction |
| jump_flag | output | 1 | Unconditional jump instruction |
| alu_ctl | output | ALU_W (3) | ALU operation code |

## Verification
The bench targets the function-field corner cases. It sends codes with bits 5..4 set to 00, 01 and 11, and it sends unlisted low nibbles. A decoder that compared all six function bits would fall back to add on the first case, and one with no default would produce an illegal or stale ALU code on the second. Branch words whose low six bits match the set-on-less-than code expose a second stage that consults the function field for the wrong ALU class. Unknown opcodes and a mid-run reset with a load present catch a decoder that leaves a write enable high. A new word driven half a cycle before the edge catches an output path that is not registered.

// File: rtl/insn_ctl_pkg.sv
package insn_ctl_pkg;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aop_e;

  typedef struct packed {
    logic dst_rd;
    logic alu_imm;
    logic wb_mem;
    logic rf_we;
    logic mem_rd;
    logic mem_we;
    logic branch;
    logic jump;
  } main_ctl_t;

  localparam logic [5:0] OPC_RTYPE = 6'd0;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_JUMP  = 6'd2;

  localparam logic [3:0] FN_ADD = 4'b0000;
  localparam logic [3:0] FN_SUB = 4'b0010;
  localparam logic [3:0] FN_AND = 4'b0100;
  localparam logic [3:0] FN_OR  = 4'b0101;
  localparam logic [3:0] FN_SLT = 4'b1010;

  localparam logic [2:0] ALU_AND = 3'b000;
  localparam logic [2:0] ALU_OR  = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

endpackage

// File: rtl/ictl_main_dec.sv
module ictl_main_dec
  import insn_ctl_pkg::*;
#(
  parameter int OPC_W = 6
) (
  input  logic [OPC_W-1:0] opc,
  output main_ctl_t        ctl,
  output aop_e             aop
);

  always_comb begin
    ctl = '0;
    aop = AOP_ADD;
    case (opc)
      OPC_RTYPE: begin
        ctl.dst_rd = 1'b1;
        ctl.rf_we  = 1'b1;
        aop        = AOP_FUNCT;
      end
      OPC_LOAD: begin
        ctl.alu_imm = 1'b1;
        ctl.wb_mem  = 1'b1;
        ctl.rf_we   = 1'b1;
        ctl.mem_rd  = 1'b1;
      end
      OPC_STORE: begin
        ctl.alu_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        aop        = AOP_SUB;
      end
      OPC_JUMP: begin
        ctl.jump = 1'b1;
      end
      default: begin
        ctl = '0;
        aop = AOP_ADD;
      end
    endcase
  end

endmodule

// File: rtl/ictl_alu_dec.sv
module ictl_alu_dec
  import insn_ctl_pkg::*;
#(
  parameter int FN_SEL_W = 4,
  parameter int ALU_W    = 3
) (
  input  aop_e                aop,
  input  logic [FN_SEL_W-1:0] fn_lo,
  output logic [ALU_W-1:0]    alu_op
);

  logic [ALU_W-1:0] fn_code;

  always_comb begin
    case (fn_lo)
      FN_ADD:  fn_code = ALU_W'(ALU_ADD);
      FN_SUB:  fn_code = ALU_W'(ALU_SUB);
      FN_AND:  fn_code = ALU_W'(ALU_AND);
      FN_OR:   fn_code = ALU_W'(ALU_OR);
      FN_SLT:  fn_code = ALU_W'(ALU_SLT);
      default: fn_code = ALU_W'(ALU_ADD);
    endcase
  end

  // Low class bit wins: class 11 never arrives and is folded into subtract.
  always_comb begin
    if (aop[0])      alu_op = ALU_W'(ALU_SUB);
    else if (aop[1]) alu_op = fn_code;
    else             alu_op = ALU_W'(ALU_ADD);
  end

endmodule

// File: rtl/ictl_out_reg.sv
module ictl_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/insn_ctl_decoder.sv
module insn_ctl_decoder
  import insn_ctl_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int OPC_W  = 6,
  parameter int FN_W   = 6,
  parameter int ALU_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] insn,
  output logic              dst_sel_rd,
  output logic              alu_src_imm,
  output logic              wb_sel_mem,
  output logic              reg_wr_en,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic              branch_flag,
  output logic              jump_flag,
  output logic [ALU_W-1:0]  alu_ctl
);

  localparam int OPC_LSB  = INSN_W - OPC_W;
  localparam int FN_SEL_W = FN_W - 2;
  localparam int MAIN_W   = $bits(main_ctl_t);
  localparam int CTL_W    = MAIN_W + ALU_W;

  logic [OPC_W-1:0]    opc;
  logic [FN_SEL_W-1:0] fn_lo;
  main_ctl_t           main_ctl;
  aop_e                aop;
  logic [ALU_W-1:0]    alu_nxt;
  logic [CTL_W-1:0]    ctl_d;
  logic [CTL_W-1:0]    ctl_q;
  main_ctl_t           main_q;

  assign opc   = insn[OPC_LSB +: OPC_W];
  assign fn_lo = insn[FN_SEL_W-1:0];

  ictl_main_dec #(.OPC_W(OPC_W)) main_i (
    .opc (opc),
    .ctl (main_ctl),
    .aop (aop)
  );

  ictl_alu_dec #(.FN_SEL_W(FN_SEL_W), .ALU_W(ALU_W)) alu_i (
    .aop    (aop),
    .fn_lo  (fn_lo),
    .alu_op (alu_nxt)
  );

  assign ctl_d = {main_ctl, alu_nxt};

  ictl_out_reg #(.W(CTL_W)) oreg_i (
    .clk (clk),
    .rst (rst),
    .d   (ctl_d),
    .q   (ctl_q)
  );

  assign main_q      = main_ctl_t'(ctl_q[CTL_W-1:ALU_W]);
  assign alu_ctl     = ctl_q[ALU_W-1:0];
  assign dst_sel_rd  = main_q.dst_rd;
  assign alu_src_imm = main_q.alu_imm;
  assign wb_sel_mem  = main_q.wb_mem;
  assign reg_wr_en   = main_q.rf_we;
  assign mem_rd_en   = main_q.mem_rd;
  assign mem_wr_en   = main_q.mem_we;
  assign branch_flag = main_q.branch;
  assign jump_flag   = main_q.jump;

endmodule

// File: rtl/insn_ctl_decoder_chk.sv
module insn_ctl_decoder_chk
  import insn_ctl_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int ALU_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [OPC_W-1:0] opc,
  input logic             dst_sel_rd,
  input logic             alu_src_imm,
  input logic             wb_sel_mem,
  input logic             reg_wr_en,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic             branch_flag,
  input logic             jump_flag,
  input logic [ALU_W-1:0] alu_ctl
);

  logic known_opc;
  assign known_opc = (opc == OPC_RTYPE) || (opc == OPC_LOAD) || (opc == OPC_STORE) ||
                     (opc == OPC_BEQ) || (opc == OPC_JUMP);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(dst_sel_rd || alu_src_imm || wb_sel_mem || reg_wr_en || mem_rd_en ||
                     mem_wr_en || branch_flag || jump_flag || (alu_ctl != '0))); // R1
  AST_DST_RD_IS_RTYPE: assert property (@(posedge clk) disable iff (rst)
    dst_sel_rd |-> (reg_wr_en && !alu_src_imm && !wb_sel_mem)); // R3
  AST_MEMRD_IS_LOAD: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (wb_sel_mem && reg_wr_en && alu_src_imm && !dst_sel_rd)); // R4
  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr_en && reg_wr_en)); // R5
  AST_BRANCH_QUIET: assert property (@(posedge clk) disable iff (rst)
    branch_flag |-> (!reg_wr_en && !mem_wr_en && alu_ctl == ALU_W'(ALU_SUB))); // R6
  AST_JUMP_FROM_OPC: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (jump_flag == ($past(opc) == OPC_JUMP))); // R7
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(known_opc)) |-> !(reg_wr_en || mem_wr_en || mem_rd_en ||
                                             branch_flag || jump_flag)); // R8
  AST_LEGAL_ALU_CODE: assert property (@(posedge clk) disable iff (rst)
    !(alu_ctl == 3'b011 || alu_ctl == 3'b100 || alu_ctl == 3'b101)); // R11

endmodule

bind insn_ctl_decoder insn_ctl_decoder_chk #(.OPC_W(OPC_W), .ALU_W(ALU_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .opc         (insn[INSN_W-1 -: OPC_W]),
  .dst_sel_rd  (dst_sel_rd),
  .alu_src_imm (alu_src_imm),
  .wb_sel_mem  (wb_sel_mem),
  .reg_wr_en   (reg_wr_en),
  .mem_rd_en   (mem_rd_en),
  .mem_wr_en   (mem_wr_en),
  .branch_flag (branch_flag),
  .jump_flag   (jump_flag),
  .alu_ctl     (alu_ctl)
);

// File: tb/insn_ctl_decoder_tb_top.sv
module insn_ctl_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] insn;
  logic        dst_sel_rd, alu_src_imm, wb_sel_mem, reg_wr_en;
  logic        mem_rd_en, mem_wr_en, branch_flag, jump_flag;
  logic [2:0]  alu_ctl;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [10:0] prev_exp;

  always #5 clk = ~clk;

  insn_ctl_decoder dut_i (
    .clk(clk), .rst(rst), .insn(insn),
    .dst_sel_rd(dst_sel_rd), .alu_src_imm(alu_src_imm), .wb_sel_mem(wb_sel_mem),
    .reg_wr_en(reg_wr_en), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .branch_flag(branch_flag), .jump_flag(jump_flag), .alu_ctl(alu_ctl)
  );

  // Packing: {dst_rd, imm, wb_mem, rf_we, mem_rd, mem_we, branch, jump, alu[2:0]}
  function automatic logic [10:0] model(input logic [31:0] w);
    logic [7:0] m;
    logic [2:0] a;
    a = 3'b010;
    case (int'(w[31:26]))
      0: begin
        m = 8'b1001_0000;
        case (int'(w[3:0]))
          0:  a = 3'b010;
          2:  a = 3'b110;
          4:  a = 3'b000;
          5:  a = 3'b001;
          10: a = 3'b111;
          default: a = 3'b010;
        endcase
      end
      35: m = 8'b0111_1000;
      43: m = 8'b0100_0100;
      4:  begin m = 8'b0000_0010; a = 3'b110; end
      2:  m = 8'b0000_0001;
      default: m = 8'b0;
    endcase
    return {m, a};
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    case (int'(w[31:26]))
      0:  return "R3/R9/R10";
      35: return "R4";
      43: return "R5";
      4:  return "R6";
      2:  return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] rtype(input logic [4:0] rs, rt, rd, sh, input logic [5:0] fn);
    return {6'd0, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input logic [10:0] exp, input string tag);
    logic [10:0] act;
    act = {dst_sel_rd, alu_src_imm, wb_sel_mem, reg_wr_en, mem_rd_en, mem_wr_en,
           branch_flag, jump_flag, alu_ctl};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s insn=%h actual=%b expected=%b", tag, insn, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input string tag);
    @(negedge clk);
    insn = w;
    #1;
    check(prev_exp, "R2 hold-before-edge");
    @(posedge clk);
    #1;
    prev_exp = model(w);
    check(prev_exp, tag);
    compared++;
    if (alu_ctl == 3'b011 || alu_ctl == 3'b100 || alu_ctl == 3'b101) begin
      mismatched++;
      $display("FAIL R11 actual=%b expected=legal code", alu_ctl);
    end
  endtask

  task automatic mid_reset(input logic [31:0] w);
    @(negedge clk);
    rst = 1'b1;
    insn = w;
    @(posedge clk);
    #1;
    check(11'd0, "R1 mid-run reset");
    @(negedge clk);
    rst = 1'b0;
    prev_exp = model(w);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    insn = rtype(5'd1, 5'd2, 5'd3, 5'd0, 6'b100000);
    repeat (3) @(posedge clk);
    #1;
    check(11'd0, "R1 reset state");
    @(negedge clk);
    rst = 1'b0;
    prev_exp = model(insn);

    // R9 mapping, with bits 5..4 varied
    apply(rtype(5'd17, 5'd18, 5'd8, 5'd0, 6'b100000), "R9 add");
    apply(rtype(5'd1, 5'd2, 5'd3, 5'd0, 6'b100010), "R9 sub");
    apply(rtype(5'd4, 5'd5, 5'd6, 5'd0, 6'b100100), "R9 and");
    apply(rtype(5'd7, 5'd8, 5'd9, 5'd0, 6'b100101), "R9 or");
    apply(rtype(5'd10, 5'd11, 5'd12, 5'd0, 6'b101010), "R9 slt");
    apply(rtype(5'd3, 5'd3, 5'd3, 5'd0, 6'b001010), "R9 slt bits5:4=00");
    apply(rtype(5'd3, 5'd3, 5'd3, 5'd0, 6'b010101), "R9 or bits5:4=01");
    apply(rtype(5'd3, 5'd3, 5'd3, 5'd0, 6'b110010), "R9 sub bits5:4=11");
    // R10 unlisted codes
    apply(rtype(5'd1, 5'd1, 5'd1, 5'd0, 6'b100111), "R10 nibble 0111");
    apply(rtype(5'd1, 5'd1, 5'd1, 5'd0, 6'b101111), "R10 nibble 1111");
    // R12 other fields vary
    apply(rtype(5'd31, 5'd0, 5'd31, 5'd31, 6'b100100), "R12 rtype fields");
    apply(itype(6'd35, 5'd2, 5'd9, 16'h8004), "R4 load");
    apply(itype(6'd35, 5'd31, 5'd1, 16'h002A), "R12 load low bits");
    apply(itype(6'd43, 5'd2, 5'd9, 16'h0010), "R5 store");
    apply(itype(6'd43, 5'd0, 5'd0, 16'hFFE2), "R12 store low bits");
    apply(itype(6'd4, 5'd12, 5'd13, 16'h002A), "R6 beq slt-like low bits");
    apply(itype(6'd4, 5'd1, 5'd2, 16'h0024), "R6 beq and-like low bits");
    apply({6'd2, 26'h3FF_FFFF}, "R7 jump");
    apply({6'd3, 26'h000_0020}, "R8 opcode 3");
    apply({6'd63, 26'h155_5555}, "R8 opcode 63");
    apply({6'd32, 26'h000_002A}, "R8 opcode 32");
    mid_reset(itype(6'd35, 5'd1, 5'd2, 16'h0004));
    apply(itype(6'd43, 5'd4, 5'd5, 16'h0008), "R5 after reset");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      logic [5:0]  op;
      r = $urandom();
      case (i % 6)
        0: op = 6'd0;
        1: op = 6'd35;
        2: op = 6'd43;
        3: op = 6'd4;
        4: op = 6'd2;
        default: op = r[31:26];
      endcase
      apply({op, r[25:0]}, tag_of({op, r[25:0]}));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule